// File: doc/BRIEF.md
# Channel Status Block Assembler

This block produces the channel-status bit that goes into each frame of a 192-frame status block. Each channel has its own status stream. A frame counter tracks where the block is. On every frame advance the block combines the serial status input of each channel with a small set of active-low dedicated control pins, and registers one status bit per channel. A professional/consumer select decides which bit positions the dedicated pins and the two-bit code input drive.

In professional mode, the last byte of each channel's block (frames 184 to 191) can carry a CRC. The CRC is computed inside the block over the bits that were actually sent in frames 0 to 183. A pass-through mode turns off all pin merging and CRC insertion, so each status bit is a copy of its serial input. Alongside the status bits, the block gives the downstream subframe encoder two flags. One marks frame 0. The other stays high for the first sixteen status bytes.

Top module: `cs_block_asm`

## Requirements
- R1: The frame counter starts at 0 after reset, advances by one on each `frame_tick`, and wraps from 191 to 0. `sof_o` is high exactly when the registered outputs belong to frame 0.
- R2: `blk_o` is high while the registered outputs belong to frames 0 to 127, and low for frames 128 to 191.
- R3: In frame 0, with pass-through off, the status bit is 1 in professional mode (`consumer_sel`=0). In consumer mode it is the serial input unchanged, OR-ed with 0.
- R4: In professional mode, `ded_n[0]`, `ded_n[1]`, `ded_n[2]` and `ded_n[3]` drive status bits 1, 6, 7 and 9. A low pin gives a 1, and the result is OR-ed with the serial input.
- R5: In professional mode, `code_sel` sets bits 2, 3 and 4 (listed as bit2 bit3 bit4): 00 gives 111, 01 gives 110, 10 gives 100, 11 gives 000. Each is OR-ed with the serial input.
- R6: In consumer mode, `ded_n[0]` to `ded_n[4]` drive status bits 2, 3, 8, 9 and 15. They are active low and OR-ed with the serial input.
- R7: In consumer mode, `code_sel` sets bits 24 and 25 (listed as bit24 bit25): 00 gives 00, 01 gives 01, 10 gives 11, 11 gives 00. `cd_mode_o` is high only for consumer mode with code 11 and pass-through off.
- R8: With professional mode, `crc_ins_en`=1 and pass-through off, frames 184 to 191 carry that channel's CRC and the serial input is ignored. The CRC register uses polynomial x^8+x^4+x^3+x^2+1 (mask 0x1D) and is preset to 0xFF at frame 0. For each transmitted bit d of frames 0 to 183 it computes fb = reg[7]^d, shifts left by one, and XORs in 0x1D when fb is 1. Frame 184+k sends register bit 7-k.
- R9: With `passthru`=1, every status bit equals that channel's serial input. The dedicated pins, `code_sel` and `crc_ins_en` have no effect.
- R10: Channel A (`ser_c[0]`, `cs_o[0]`) and channel B (`ser_c[1]`, `cs_o[1]`) are merged independently, and each has its own CRC.
- R11: Reset clears `cs_o`, `blk_o` and `sof_o` to 0. The registered outputs change only on a cycle with `frame_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per frame; registers the status bits of the current frame |
| ser_c | input | 2 | Serial status input, bit 0 channel A, bit 1 channel B |
| consumer_sel | input | 1 | 0 professional, 1 consumer |
| passthru | input | 1 | 1 sends the serial status unaltered |
| crc_ins_en | input | 1 | Enables CRC in the last byte (professional only) |
| ded_n | input | 5 | Active-low dedicated status pins, meaning set by mode |
| code_sel | input | 2 | Emphasis code (professional) or rate code (consumer) |
| cs_o | output | 2 | Registered status bit per channel |
| blk_o | output | 1 | High for the frames of status bytes 0 to 15 |
| sof_o | output | 1 | High for frame 0 of the block |
| cd_mode_o | output | 1 | Consumer rate code 11 selected |

## Verification
The hardest situation to reach is the CRC byte. Its value depends on all 184 merged bits that came before it in the same block, so it can only be checked after a full, correctly aligned block has been driven with a known pin setup and known serial patterns. The stimulus therefore runs one complete block per vector, starting at frame 0. It keeps a record of the bits the bench expects in each frame and computes the CRC from that record when frame 184 arrives. It also drives serial ones into the CRC frames to show that they are ignored there. A reset in the middle of a block shows that the counter goes back to frame 0.

// File: rtl/cs_pkg.sv
// Package: shared constants for the channel-status block assembler.
// Assumes a 192-frame block and an 8-bit CRC in the final byte.
package cs_pkg;
    localparam int CS_FRAMES     = 192;
    localparam int CS_BLK_FRAMES = 128;
    localparam int CS_CRC_W      = 8;
    localparam logic [CS_CRC_W-1:0] CS_CRC_POLY = 8'h1D;
    localparam logic [CS_CRC_W-1:0] CS_CRC_INIT = 8'hFF;
    typedef enum logic { MODE_PRO = 1'b0, MODE_CONS = 1'b1 } cs_mode_e;
endpackage

// File: rtl/cs_frame_ctr.sv
// Frame position counter: counts frame advances and wraps at the block end.
// Assumes adv is a single-cycle pulse per frame.
module cs_frame_ctr #(
    parameter int NUM_FRAMES = 192,
    localparam int FW = $clog2(NUM_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [FW-1:0] frm
);
    localparam logic [FW-1:0] LAST = FW'(NUM_FRAMES - 1);

    // Advance the position, wrapping after the last frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frm <= '0;
        else if (adv)
            frm <= (frm == LAST) ? '0 : frm + 1'b1;
    end
endmodule

// File: rtl/cs_pin_map.sv
// Dedicated pin mapper: gives the pin-driven status bit for the current frame.
// Pins are active low. The meaning of ded_n and code_sel depends on the mode.
module cs_pin_map #(
    parameter int FW = 8
) (
    input  logic          consumer,
    input  logic [FW-1:0] frm,
    input  logic [4:0]    ded_n,
    input  logic [1:0]    code_sel,
    output logic          ded_bit
);
    // Choose the bit value for this frame position from the mode tables.
    always_comb begin
        ded_bit = 1'b0;
        if (!consumer) begin
            case (int'(frm))
                0: ded_bit = 1'b1;
                1: ded_bit = ~ded_n[0];
                2: ded_bit = (code_sel != 2'b11);
                3: ded_bit = ~code_sel[1];
                4: ded_bit = (code_sel == 2'b00);
                6: ded_bit = ~ded_n[1];
                7: ded_bit = ~ded_n[2];
                9: ded_bit = ~ded_n[3];
                default: ded_bit = 1'b0;
            endcase
        end else begin
            case (int'(frm))
                2:  ded_bit = ~ded_n[0];
                3:  ded_bit = ~ded_n[1];
                8:  ded_bit = ~ded_n[2];
                9:  ded_bit = ~ded_n[3];
                15: ded_bit = ~ded_n[4];
                24: ded_bit = (code_sel == 2'b10);
                25: ded_bit = code_sel[1] ^ code_sel[0];
                default: ded_bit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cs_crc_gen.sv
// Per-channel serial CRC: accumulates the sent bits before the CRC byte,
// then shifts the result out MSB first during the CRC byte.
// Assumes frm is the position of the bit being sent when adv is high.
module cs_crc_gen #(
    parameter int FW = 8,
    parameter int W = 8,
    parameter int START = 184,
    parameter logic [W-1:0] POLY = 8'h1D,
    parameter logic [W-1:0] INIT = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [FW-1:0] frm,
    input  logic          din,
    output logic          crc_msb
);
    logic [W-1:0] reg_q, base, stepped;

    // Preset at the block start, then one polynomial step per data bit.
    assign base    = (frm == '0) ? INIT : reg_q;
    assign stepped = {base[W-2:0], 1'b0} ^ ((base[W-1] ^ din) ? POLY : '0);

    // Update on each frame: accumulate before START, shift out after.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= INIT;
        else if (adv)
            reg_q <= (frm < FW'(START)) ? stepped : {reg_q[W-2:0], 1'b0};
    end

    assign crc_msb = reg_q[W-1];
endmodule

// File: rtl/cs_block_asm.sv
// Channel-status block assembler top: merges the serial status with the
// dedicated pins, inserts the optional CRC and registers the per-frame bits
// with block-start flags. Assumes inputs are stable in the frame_tick cycle.
module cs_block_asm
    import cs_pkg::*;
#(
    parameter int NUM_FRAMES = CS_FRAMES,
    parameter int BLK_FRAMES = CS_BLK_FRAMES,
    parameter int CRC_W      = CS_CRC_W,
    parameter int NUM_CH     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic [NUM_CH-1:0] ser_c,
    input  logic              consumer_sel,
    input  logic              passthru,
    input  logic              crc_ins_en,
    input  logic [4:0]        ded_n,
    input  logic [1:0]        code_sel,
    output logic [NUM_CH-1:0] cs_o,
    output logic              blk_o,
    output logic              sof_o,
    output logic              cd_mode_o
);
    localparam int FW = $clog2(NUM_FRAMES);
    localparam int CRC_START = NUM_FRAMES - CRC_W;

    logic [FW-1:0]     frm_q;
    logic              ded_bit;
    logic              crc_active;
    logic [NUM_CH-1:0] crc_msb, tx_bit;

    cs_frame_ctr #(.NUM_FRAMES(NUM_FRAMES)) u_ctr (
        .clk(clk), .rst_n(rst_n), .adv(frame_tick), .frm(frm_q)
    );

    cs_pin_map #(.FW(FW)) u_map (
        .consumer(consumer_sel == MODE_CONS), .frm(frm_q), .ded_n(ded_n),
        .code_sel(code_sel), .ded_bit(ded_bit)
    );

    // CRC byte replaces the merged bits only in professional non-pass-through mode.
    assign crc_active = crc_ins_en && (consumer_sel == MODE_PRO) && !passthru
                        && (frm_q >= FW'(CRC_START));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Merge the serial bit with the pin bit, or pick the CRC bit.
        assign tx_bit[ch] = crc_active ? crc_msb[ch]
                          : (passthru ? ser_c[ch] : (ser_c[ch] | ded_bit));

        cs_crc_gen #(
            .FW(FW), .W(CRC_W), .START(CRC_START),
            .POLY(CS_CRC_POLY), .INIT(CS_CRC_INIT)
        ) u_crc (
            .clk(clk), .rst_n(rst_n), .adv(frame_tick), .frm(frm_q),
            .din(tx_bit[ch]), .crc_msb(crc_msb[ch])
        );
    end

    // Register the status bits and position flags once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_o  <= '0;
            blk_o <= 1'b0;
            sof_o <= 1'b0;
        end else if (frame_tick) begin
            cs_o  <= tx_bit;
            blk_o <= (frm_q < FW'(BLK_FRAMES));
            sof_o <= (frm_q == '0);
        end
    end

    assign cd_mode_o = (consumer_sel == MODE_CONS) && !passthru && (code_sel == 2'b11);
endmodule

// File: rtl/cs_block_asm_chk.sv
// Checker for cs_block_asm: temporal properties on the ports and frame counter.
module cs_block_asm_chk #(
    parameter int FW = 8,
    parameter int NUM_FRAMES = 192,
    parameter int BLK_FRAMES = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_tick,
    input logic [1:0]    ser_c,
    input logic          consumer_sel,
    input logic          passthru,
    input logic [FW-1:0] frm,
    input logic [1:0]    cs_o,
    input logic          blk_o,
    input logic          sof_o
);
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && (frm == FW'(NUM_FRAMES - 1)) |=> (frm == '0));
    p_sof_blk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && (frm == '0) |=> sof_o && blk_o);
    p_blk_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && (frm == FW'(BLK_FRAMES)) |=> !blk_o && !sof_o);
    p_pro_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && (frm == '0) && !consumer_sel && !passthru |=> (cs_o == 2'b11));
    p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && passthru |=> (cs_o == $past(ser_c)));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(cs_o) && $stable(blk_o) && $stable(sof_o));
endmodule

bind cs_block_asm cs_block_asm_chk #(
    .FW(FW), .NUM_FRAMES(NUM_FRAMES), .BLK_FRAMES(BLK_FRAMES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .ser_c(ser_c),
    .consumer_sel(consumer_sel), .passthru(passthru), .frm(frm_q),
    .cs_o(cs_o), .blk_o(blk_o), .sof_o(sof_o)
);

// File: tb/cs_block_asm_tb_top.sv
// Bench for cs_block_asm: one full block per table vector, then directed tests.
module cs_block_asm_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic [1:0] ser_c = '0;
    logic       consumer_sel = 1'b0;
    logic       passthru = 1'b0;
    logic       crc_ins_en = 1'b0;
    logic [4:0] ded_n = '1;
    logic [1:0] code_sel = '0;
    logic [1:0] cs_o;
    logic       blk_o, sof_o, cd_mode_o;

    int n_chk = 0;
    int n_bad = 0;
    logic hist [2][184];

    always #2.5 clk = ~clk;

    cs_block_asm dut_i (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .ser_c(ser_c),
        .consumer_sel(consumer_sel), .passthru(passthru), .crc_ins_en(crc_ins_en),
        .ded_n(ded_n), .code_sel(code_sel), .cs_o(cs_o), .blk_o(blk_o),
        .sof_o(sof_o), .cd_mode_o(cd_mode_o)
    );

    // Vector: {consumer, passthru, crc_en, ded_n[4:0], code_sel[1:0], pattern[1:0]}
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 5'b11111, 2'b00, 2'd0},
        {1'b0, 1'b0, 1'b0, 5'b00000, 2'b01, 2'd0},
        {1'b0, 1'b0, 1'b1, 5'b10101, 2'b10, 2'd1},
        {1'b0, 1'b0, 1'b1, 5'b01010, 2'b11, 2'd3},
        {1'b1, 1'b0, 1'b0, 5'b11111, 2'b01, 2'd0},
        {1'b1, 1'b0, 1'b0, 5'b00000, 2'b10, 2'd1},
        {1'b1, 1'b0, 1'b1, 5'b01101, 2'b11, 2'd2},
        {1'b0, 1'b1, 1'b1, 5'b00000, 2'b00, 2'd1}
    };

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, got, exp);
        end
    endtask

    // Pin-driven bits of a whole block, written from the mode tables.
    function automatic logic [191:0] pin_mask(logic cons, logic [4:0] d, logic [1:0] s);
        logic [191:0] m = '0;
        if (!cons) begin
            m[0] = 1'b1; m[1] = !d[0]; m[6] = !d[1]; m[7] = !d[2]; m[9] = !d[3];
            if (s == 2'b00) begin m[2] = 1'b1; m[3] = 1'b1; m[4] = 1'b1; end
            if (s == 2'b01) begin m[2] = 1'b1; m[3] = 1'b1; end
            if (s == 2'b10) m[2] = 1'b1;
        end else begin
            m[2] = !d[0]; m[3] = !d[1]; m[8] = !d[2]; m[9] = !d[3]; m[15] = !d[4];
            if (s == 2'b01) m[25] = 1'b1;
            if (s == 2'b10) begin m[24] = 1'b1; m[25] = 1'b1; end
        end
        return m;
    endfunction

    function automatic logic [1:0] pat_bits(logic [1:0] p, int f);
        case (p)
            2'd1: return {f % 7 == 3, f % 5 == 1};
            2'd2: return {f % 11 == 5, f % 3 == 0};
            2'd3: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [7:0] ref_crc(int ch);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < 184; i++) begin
            logic fb = c[7] ^ hist[ch][i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h1D;
        end
        return c;
    endfunction

    task automatic frame(input logic [1:0] s);
        @(negedge clk);
        ser_c = s;
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 reset", {cs_o, blk_o, sof_o}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset idle", {cs_o, blk_o, sof_o}, 4'b0000);

        for (int v = 0; v < 8; v++) begin
            logic [11:0] vec = VEC[v];
            logic [191:0] m;
            logic [7:0] crc [2];
            logic ins;
            consumer_sel = vec[11];
            passthru = vec[10];
            crc_ins_en = vec[9];
            ded_n = vec[8:4];
            code_sel = vec[3:2];
            m = pin_mask(vec[11], vec[8:4], vec[3:2]);
            ins = vec[9] && !vec[11] && !vec[10];
            @(negedge clk);
            // R7: CD flag
            chk("R7 cd_mode", {3'b000, cd_mode_o},
                {3'b000, vec[11] && !vec[10] && vec[3:2] == 2'b11});
            for (int f = 0; f < 192; f++) begin
                logic [1:0] s = pat_bits(vec[1:0], f);
                logic [1:0] e;
                string tag;
                if (ins && f == 184) begin
                    crc[0] = ref_crc(0);
                    crc[1] = ref_crc(1);
                end
                // R10: each channel is computed on its own
                for (int ch = 0; ch < 2; ch++) begin
                    if (ins && f >= 184) e[ch] = crc[ch][7 - (f - 184)];
                    else if (vec[10]) e[ch] = s[ch];
                    else e[ch] = s[ch] | m[f];
                    if (f < 184) hist[ch][f] = e[ch];
                end
                if (vec[10]) tag = "R9 passthru";
                else if (ins && f >= 184) tag = "R8 crc";
                else if (f == 0) tag = "R3 bit0";
                else if (vec[11] && (f == 24 || f == 25)) tag = "R7 rate";
                else if (!vec[11] && f >= 2 && f <= 4) tag = "R5 emphasis";
                else if (vec[11]) tag = "R6 consumer pins";
                else tag = "R4 pro pins";
                frame(s);
                chk(tag, {2'b00, cs_o}, {2'b00, e});
                // R1 R2: position flags
                chk("R1 R2 flags", {2'b00, blk_o, sof_o}, {2'b00, f < 128, f == 0});
            end
        end

        // R11: outputs hold without frame_tick
        begin
            logic [3:0] snap = {cs_o, blk_o, sof_o};
            ser_c = 2'b11;
            passthru = 1'b1;
            repeat (5) @(negedge clk);
            chk("R11 hold", {cs_o, blk_o, sof_o}, snap);
        end

        // R1: reset in the middle of a block returns to frame 0
        passthru = 1'b0;
        consumer_sel = 1'b0;
        crc_ins_en = 1'b0;
        ded_n = '1;
        for (int f = 0; f < 50; f++) frame(2'b00);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 mid reset", {cs_o, blk_o, sof_o}, 4'b0000);
        rst_n = 1'b1;
        frame(2'b00);
        chk("R1 restart", {cs_o, blk_o, sof_o}, 4'b1111);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule